// File: doc/BRIEF.md
# Preset-and-Negate Flag ALU

This block is a 16-bit arithmetic and logic unit with no opcode decoder. Six independent control bits steer a fixed pipeline of stages. Each operand may first be cleared to zero and then bitwise inverted. The two prepared operands are then either added (two's complement, carry dropped) or bitwise ANDed. The result may finally be inverted. Two status flags, zero and negative, are derived from that final result.

Because the stages are ordered and each is optional, the same hardware yields constants (0, 1, -1), pass-through of either operand, negation, increment, decrement, sum, difference, AND and OR. Which one is chosen depends only on how the six bits are set. The result and both flags are registered, so they appear one clock after the inputs are sampled.

Top module: `preset_negate_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the next outputs are `res` = 0, `is_zero` = 1 and `is_neg` = 0.
- R2: Outputs change only at a rising clock edge, and after it they reflect the inputs sampled at that edge (latency of one cycle).
- R3: When `clr_a` is 1, operand A is replaced by zero before any inversion; `clr_b` does the same for operand B.
- R4: When `inv_a` is 1, the possibly cleared A is bitwise inverted; `inv_b` does the same for B.
- R5: When `sel_add` is 1, the core result is the sum of the prepared operands modulo 2^16, and the carry out of bit 15 is dropped.
- R6: When `sel_add` is 0, the core result is the bitwise AND of the prepared operands.
- R7: When `inv_res` is 1, `res` is the bitwise inverse of the core result; otherwise it equals the core result.
- R8: `is_zero` is 1 exactly when all 16 bits of `res` are 0.
- R9: `is_neg` always equals bit 15 of `res`.
- R10: Both flags are taken from the result after the optional final inversion, not from the core result.
- R11: With the control bits written as {clr_a, inv_a, clr_b, inv_b, sel_add, inv_res}, pattern 101010 gives 0, 111111 gives 1, 111010 gives 16'hFFFF, 000010 gives A+B and 010011 gives A-B, whatever the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| opa | input | 16 | Operand A |
| opb | input | 16 | Operand B |
| clr_a | input | 1 | Clear operand A to zero |
| inv_a | input | 1 | Invert operand A after the clear stage |
| clr_b | input | 1 | Clear operand B to zero |
| inv_b | input | 1 | Invert operand B after the clear stage |
| sel_add | input | 1 | 1 selects addition, 0 selects bitwise AND |
| inv_res | input | 1 | Invert the core result |
| res | output | 16 | Registered result |
| is_zero | output | 1 | Registered flag: result equals zero |
| is_neg | output | 1 | Registered flag: result bit 15 set |

## Verification
Directed cases separate the stage order: clearing then inverting an operand must give all ones, which would differ if the order were swapped, and an addition wrapping from 16'hFFFF+1 to zero shows that the carry is dropped and that the zero flag follows. Inverting an all-ones AND result to zero, and inverting a zero sum to all ones, shows that flags come from the final value rather than the core result. The five named control patterns are tried with several operand pairs to confirm that constants ignore the operands and that the sum and difference hold across signs. Random operands under random control bits, compared with a bench model, then cover all 64 control combinations.

// File: rtl/pn_alu_pkg.sv
`timescale 1ns/1ps
package pn_alu_pkg;

  // Number of operands that pass through a preparation stage.
  localparam int unsigned NUM_OPS = 2;

  // Controls for one operand preparation stage; clear acts before invert.
  typedef struct packed {
    logic clr;
    logic inv;
  } prep_ctl_t;

  // Core function select.
  typedef enum logic {
    FN_AND = 1'b0,
    FN_ADD = 1'b1
  } core_fn_e;

endpackage

// File: rtl/pn_operand_prep.sv
`timescale 1ns/1ps
module pn_operand_prep #(
  parameter int unsigned W = 16
) (
  input  logic                  [W-1:0] din,
  input  pn_alu_pkg::prep_ctl_t         ctl,
  output logic                  [W-1:0] dout
);

  logic [W-1:0] cleared;

  always_comb begin
    cleared = ctl.clr ? '0 : din;
    dout    = ctl.inv ? ~cleared : cleared;
  end

endmodule

// File: rtl/pn_core.sv
`timescale 1ns/1ps
module pn_core #(
  parameter int unsigned W = 16
) (
  input  logic                 [W-1:0] a,
  input  logic                 [W-1:0] b,
  input  pn_alu_pkg::core_fn_e         fn,
  input  logic                         inv_out,
  output logic                 [W-1:0] y
);

  logic [W-1:0] sum_w;
  logic [W-1:0] and_w;
  logic [W-1:0] core_w;

  // Carry out of the top bit is intentionally discarded.
  assign sum_w = a + b;
  assign and_w = a & b;

  always_comb begin
    core_w = (fn == pn_alu_pkg::FN_ADD) ? sum_w : and_w;
    y      = inv_out ? ~core_w : core_w;
  end

endmodule

// File: rtl/pn_flags.sv
`timescale 1ns/1ps
module pn_flags #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] value,
  output logic         zero,
  output logic         neg
);

  assign zero = ~|value;
  assign neg  = value[W-1];

endmodule

// File: rtl/preset_negate_alu.sv
`timescale 1ns/1ps
module preset_negate_alu #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         clr_a,
  input  logic         inv_a,
  input  logic         clr_b,
  input  logic         inv_b,
  input  logic         sel_add,
  input  logic         inv_res,
  output logic [W-1:0] res,
  output logic         is_zero,
  output logic         is_neg
);

  import pn_alu_pkg::*;

  logic      [W-1:0] raw_op  [NUM_OPS];
  logic      [W-1:0] prep_op [NUM_OPS];
  prep_ctl_t         prep_ctl[NUM_OPS];
  logic      [W-1:0] res_d;
  logic              zero_d;
  logic              neg_d;
  core_fn_e          fn_sel;

  assign raw_op[0]   = opa;
  assign raw_op[1]   = opb;
  assign prep_ctl[0] = '{clr: clr_a, inv: inv_a};
  assign prep_ctl[1] = '{clr: clr_b, inv: inv_b};
  assign fn_sel      = sel_add ? FN_ADD : FN_AND;

  for (genvar g = 0; g < NUM_OPS; g++) begin : g_prep
    pn_operand_prep #(.W(W)) u_prep (
      .din  (raw_op[g]),
      .ctl  (prep_ctl[g]),
      .dout (prep_op[g])
    );
  end

  pn_core #(.W(W)) u_core (
    .a       (prep_op[0]),
    .b       (prep_op[1]),
    .fn      (fn_sel),
    .inv_out (inv_res),
    .y       (res_d)
  );

  // Flags are derived from the final (post-inversion) value.
  pn_flags #(.W(W)) u_flags (
    .value (res_d),
    .zero  (zero_d),
    .neg   (neg_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res     <= '0;
      is_zero <= 1'b1;
      is_neg  <= 1'b0;
    end else begin
      res     <= res_d;
      is_zero <= zero_d;
      is_neg  <= neg_d;
    end
  end

endmodule

// File: rtl/preset_negate_alu_chk.sv
`timescale 1ns/1ps
module preset_negate_alu_chk #(
  parameter int unsigned W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] opa,
  input logic [W-1:0] opb,
  input logic         clr_a,
  input logic         inv_a,
  input logic         clr_b,
  input logic         inv_b,
  input logic         sel_add,
  input logic         inv_res,
  input logic [W-1:0] res,
  input logic         is_zero,
  input logic         is_neg
);

  logic [5:0] ctl;
  assign ctl = {clr_a, inv_a, clr_b, inv_b, sel_add, inv_res};

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (res == '0 && is_zero && !is_neg)); // R1

  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (is_zero == (res == '0))); // R8

  AST_NEG_FLAG: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (is_neg == res[W-1])); // R9

  AST_PLAIN_SUM: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctl) == 6'b000010) |-> (res == W'($past(opa) + $past(opb)))); // R5

  AST_PLAIN_AND: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctl) == 6'b000000) |-> (res == ($past(opa) & $past(opb)))); // R6

  AST_CONST_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctl) == 6'b101010) |-> (res == '0 && is_zero)); // R11

  AST_CONST_ONES: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(ctl) == 6'b111010) |-> (res == '1 && is_neg)); // R11

  AST_HOLD_INPUTS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(opa) && $stable(opb) && $stable(ctl)) |=> $stable(res)); // R2

endmodule

bind preset_negate_alu preset_negate_alu_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .opa     (opa),
  .opb     (opb),
  .clr_a   (clr_a),
  .inv_a   (inv_a),
  .clr_b   (clr_b),
  .inv_b   (inv_b),
  .sel_add (sel_add),
  .inv_res (inv_res),
  .res     (res),
  .is_zero (is_zero),
  .is_neg  (is_neg)
);

// File: tb/preset_negate_alu_tb.sv
`timescale 1ns/1ps
module preset_negate_alu_tb;

  localparam int unsigned W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] xa  = '0;
  logic [W-1:0] xb  = '0;
  logic [5:0]   ctl = '0;
  logic [W-1:0] res;
  logic         is_zero;
  logic         is_neg;
  int           checks = 0;
  int           errors = 0;
  bit           done   = 1'b0;

  always #2.5 clk = ~clk;

  preset_negate_alu #(.W(W)) u_dut (
    .clk     (clk),
    .rst     (rst),
    .opa     (xa),
    .opb     (xb),
    .clr_a   (ctl[5]),
    .inv_a   (ctl[4]),
    .clr_b   (ctl[3]),
    .inv_b   (ctl[2]),
    .sel_add (ctl[1]),
    .inv_res (ctl[0]),
    .res     (res),
    .is_zero (is_zero),
    .is_neg  (is_neg)
  );

  // Bench model built from the requirements: {neg, zero, result}.
  function automatic logic [W+1:0] model(logic [5:0] c, logic [W-1:0] a, logic [W-1:0] b);
    logic [W-1:0] x, y, r;
    x = c[5] ? '0 : a;
    if (c[4]) x = ~x;
    y = c[3] ? '0 : b;
    if (c[2]) y = ~y;
    r = c[1] ? W'(x + y) : (x & y);
    if (c[0]) r = ~r;
    return {r[W-1], (r == '0), r};
  endfunction

  task automatic expect_out(string tag, logic [W-1:0] er, logic ez, logic en);
    checks++;
    if (res !== er || is_zero !== ez || is_neg !== en) begin
      errors++;
      $display("FAIL %s: got res=%h zero=%b neg=%b, expected res=%h zero=%b neg=%b",
               tag, res, is_zero, is_neg, er, ez, en);
    end
  endtask

  task automatic run(string tag, logic [5:0] c, logic [W-1:0] a, logic [W-1:0] b,
                     logic [W-1:0] er, logic ez, logic en);
    @(negedge clk);
    ctl = c; xa = a; xb = b;
    @(negedge clk);
    expect_out(tag, er, ez, en);
  endtask

  task automatic run_model(string tag, logic [5:0] c, logic [W-1:0] a, logic [W-1:0] b);
    logic [W+1:0] m;
    m = model(c, a, b);
    run(tag, c, a, b, m[W-1:0], m[W], m[W+1]);
  endtask

  initial begin
    void'($urandom(32'd2024));
    // R1: drive non-trivial inputs while in reset; outputs must stay at reset values.
    ctl = 6'b000010; xa = 16'h8000; xb = 16'h0001;
    repeat (3) @(negedge clk);
    expect_out("R1 reset state", 16'h0000, 1'b1, 1'b0);
    rst = 1'b0;

    // R2: one-cycle latency; output changes at the first edge after inputs settle.
    @(negedge clk);
    ctl = 6'b000000; xa = 16'hFFFF; xb = 16'h1234;
    @(posedge clk); #1;
    expect_out("R2 latency", 16'h1234, 1'b0, 1'b0);

    run("R3 clear A then add", 6'b100010, 16'hABCD, 16'h0042, 16'h0042, 1'b0, 1'b0);
    run("R3 clear B then add", 6'b001010, 16'h0777, 16'hFFFF, 16'h0777, 1'b0, 1'b0);
    run("R4 clear then invert A", 6'b110000, 16'h1234, 16'h5A5A, 16'h5A5A, 1'b0, 1'b0);
    run("R4 invert A only", 6'b010000, 16'h0F0F, 16'hFFFF, 16'hF0F0, 1'b0, 1'b1);
    run("R4 invert B decrement", 6'b000110, 16'h0000, 16'h0000, 16'hFFFF, 1'b0, 1'b1);
    run("R5 carry dropped", 6'b000010, 16'hFFFF, 16'h0001, 16'h0000, 1'b1, 1'b0);
    run("R5 sum", 6'b000010, 16'h1234, 16'h1111, 16'h2345, 1'b0, 1'b0);
    run("R6 bitwise and", 6'b000000, 16'hF0F0, 16'h3C3C, 16'h3030, 1'b0, 1'b0);
    run("R7 nand", 6'b000001, 16'hF0F0, 16'h3C3C, 16'hCFCF, 1'b0, 1'b1);
    run("R8 zero from and", 6'b000000, 16'hAAAA, 16'h5555, 16'h0000, 1'b1, 1'b0);
    run("R9 neg from sum", 6'b000010, 16'h7FFF, 16'h0001, 16'h8000, 1'b0, 1'b1);
    run("R10 inverted ones to zero", 6'b000001, 16'hFFFF, 16'hFFFF, 16'h0000, 1'b1, 1'b0);
    run("R10 inverted zero sum", 6'b000011, 16'hFFFF, 16'h0001, 16'hFFFF, 1'b0, 1'b1);

    for (int i = 0; i < 3; i++) begin
      logic [W-1:0] a, b;
      a = W'($urandom);
      b = W'($urandom);
      run("R11 pattern 101010", 6'b101010, a, b, 16'h0000, 1'b1, 1'b0);
      run("R11 pattern 111111", 6'b111111, a, b, 16'h0001, 1'b0, 1'b0);
      run("R11 pattern 111010", 6'b111010, a, b, 16'hFFFF, 1'b0, 1'b1);
      run_model("R11 pattern 000010", 6'b000010, a, b);
      run_model("R11 pattern 010011", 6'b010011, a, b);
      checks++;
      if (res !== W'(a - b)) begin
        errors++;
        $display("FAIL R11 difference: got %h expected %h", res, W'(a - b));
      end
    end

    // R2..R10: random controls and operands against the bench model.
    for (int i = 0; i < 400; i++) begin
      run_model("R2 random", 6'($urandom), W'($urandom), W'($urandom));
    end

    // R1: reset during operation.
    @(negedge clk);
    ctl = 6'b111010; rst = 1'b1;
    @(negedge clk);
    expect_out("R1 mid-run reset", 16'h0000, 1'b1, 1'b0);
    rst = 1'b0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule